// File: doc/BRIEF.md
# SCSI Controller Host Register Front End

This block is the byte-wide register window that a host processor uses to drive a small SCSI bus controller. The host sees a 4-bit register index and moves bytes through a write strobe and a read strobe. The block holds the transfer-count registers, a configuration register, a byte FIFO, and three registers that report the controller's state: status, interrupt and sequence step. It drives a single level-sensitive interrupt line.

Writing a byte to the command register decodes an opcode. The block runs the housekeeping commands itself: no-op, FIFO flush, chip reset, bus reset, initiator complete, message accepted, enable selection and set attention. The three selection commands go to an external sequencer through a one-cycle start strobe that carries the opcode and the DMA flag. A read of the interrupt register has side effects. The host receives the old value, and on the same clock edge the pending condition is cleared.

Register index map (host_addr): 0 transfer count low, 1 transfer count middle, 2 FIFO data, 3 command (write only, reads 0), 4 status, 5 interrupt, 6 sequence step, 7 FIFO flags (entry count), 8 config 1, 9 transfer count high / chip id (read only). Any other index reads 0 and ignores writes. Command byte layout: bit 7 is the DMA flag and bits 6:0 are the opcode. Status register bits: bit 7 is interrupt pending, bit 4 is terminal count, and bits 2:0 are the bus phase, where 7 means message-in. Interrupt register codes: 0x80 bus reset, 0x20 disconnect, 0x08 function complete. The command-done sequence step is 4.

Top module: `scsi_hif_top`

## Requirements
- R1: After reset, index 9 reads 0x04 and index 8 reads 0x07. Every other register reads 0x00 and irq is low.
- R2: A read of index 5 returns the value the register held before the read. On that clock edge the interrupt register becomes 0x00, status bits 7 and 4 clear, the sequence step becomes 4, and irq drops.
- R3: irq always equals status bit 7. Only an interrupt-raising command can set it.
- R4: Opcode 0x01 (flush) empties the FIFO, so the flags read 0. It sets the interrupt register to 0x08 and the sequence step to 0, and leaves irq unchanged.
- R5: Opcode 0x03 (bus reset) sets the interrupt register to 0x80 and pulses bus_rst_req for one cycle. It sets status bit 7 and raises irq only when config 1 bit 6 is 0.
- R6: Opcode 0x11 (initiator complete) loads the FIFO with tgt_status and then 0x00, so the flags read 2. It sets the interrupt register to 0x08, sets status bits 2:0 to 7 and raises irq.
- R7: Opcode 0x12 (message accepted) sets the interrupt register to 0x20, clears the sequence step, empties the FIFO and raises irq.
- R8: Opcode 0x44 (enable selection) clears only the interrupt register. irq and the other registers keep their values.
- R9: A command with bit 7 set and a recognised opcode copies the last values written to indices 0 and 1 into their readable copies. Before that, writes to indices 0 and 1 do not change what they read.
- R10: Opcodes 0x41, 0x42 and 0x43 pulse seq_start in the cycle after the write, with seq_op set to the opcode and seq_dma set to bit 7. No register changes.
- R11: Any other opcode pulses cmd_err for one cycle. It changes no register, including the transfer-count reload, and irq does not change.
- R12: Opcode 0x02 (chip reset) returns every register, the FIFO and irq to the R1 values.
- R13: Opcode 0x1a pulses atn_set for one cycle and 0x00 does nothing. At most one of seq_start, atn_set, bus_rst_req and cmd_err is high in any cycle.
- R14: Writes to index 2 push bytes and reads pop them in first-in, first-out order. Index 7 reads the entry count. A read of an empty FIFO returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe (takes priority over host_rd) |
| host_rd | input | 1 | Register read strobe; side effects act at the clock edge |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational from current state |
| tgt_status | input | 8 | Target status byte loaded by initiator complete |
| tc_hit | input | 1 | Terminal count reached; sets status bit 4 |
| irq | output | 1 | Level interrupt request |
| seq_start | output | 1 | One-cycle start strobe to the selection sequencer |
| seq_op | output | 7 | Opcode that goes with seq_start |
| seq_dma | output | 1 | DMA flag that goes with seq_start |
| atn_set | output | 1 | One-cycle request to assert ATN |
| bus_rst_req | output | 1 | One-cycle request to reset the SCSI bus |
| cmd_err | output | 1 | One-cycle strobe for an unrecognised opcode |

## Verification
The bound checker checks these on every cycle:
- irq falls after any interrupt-register read.
- irq never rises except after a command write.
- A bus reset with reporting enabled raises irq.
- A selection opcode produces a start strobe carrying the written opcode.
- An unrecognised opcode leaves irq alone while flagging an error.
- The outgoing strobes are mutually exclusive.

Register contents are shown only by the bench's scenarios: the FIFO contents and order, the exact interrupt and sequence values after each command, the transfer-count reload, the config-bit mask and the return to defaults on chip reset.

// File: rtl/scsi_hif_pkg.sv
// Package: shared register indices, bit codes and command classes for the
// SCSI host register front end. Assumes byte-wide registers.
package scsi_hif_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_TCLO  = 4'd0;
    localparam logic [ADDR_W-1:0] A_TCMID = 4'd1;
    localparam logic [ADDR_W-1:0] A_FIFO  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd4;
    localparam logic [ADDR_W-1:0] A_INTR  = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEQ   = 4'd6;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd7;
    localparam logic [ADDR_W-1:0] A_CFG1  = 4'd8;
    localparam logic [ADDR_W-1:0] A_TCHI  = 4'd9;

    localparam int ST_PEND = 7;
    localparam int ST_TC   = 4;
    localparam logic [2:0] PH_MSGIN = 3'd7;

    localparam logic [BYTE_W-1:0] IV_BUSRST = 8'h80;
    localparam logic [BYTE_W-1:0] IV_DISC   = 8'h20;
    localparam logic [BYTE_W-1:0] IV_FDONE  = 8'h08;

    localparam logic [2:0] SEQ_DONE = 3'd4;
    localparam int CFG_REPDIS = 6;

    typedef enum logic [3:0] {
        K_NOP, K_FLUSH, K_CHIPRST, K_BUSRST, K_ICCS,
        K_MSGACC, K_SATN, K_SEL, K_ENSEL, K_BAD
    } cmd_kind_e;

endpackage

// File: rtl/scsi_hif_cmd_dec.sv
// Command decoder: classifies a command byte into a command kind and
// extracts its DMA flag. Purely combinational; assumes bit 7 is the DMA flag.
module scsi_hif_cmd_dec
    import scsi_hif_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_kind_e         kind,
    output logic              dma
);

    // Map the 7-bit opcode onto a command class.
    always_comb begin
        dma = cmd_byte[BYTE_W-1];
        unique case (cmd_byte[6:0])
            7'h00:   kind = K_NOP;
            7'h01:   kind = K_FLUSH;
            7'h02:   kind = K_CHIPRST;
            7'h03:   kind = K_BUSRST;
            7'h11:   kind = K_ICCS;
            7'h12:   kind = K_MSGACC;
            7'h1a:   kind = K_SATN;
            7'h41,
            7'h42,
            7'h43:   kind = K_SEL;
            7'h44:   kind = K_ENSEL;
            default: kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/scsi_hif_fifo.sv
// Byte FIFO between host and bus side: host push/pop, clear, and a one-shot
// load of a two-byte status/message pair. Assumes push and pop never coincide
// with clear or load; a push when full and a pop when empty are dropped.
module scsi_hif_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load_pair,
    input  logic [W-1:0]  pair_byte,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rptr];

    // Next pointer value with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage, pointers and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (load_pair) begin
            mem[0] <= pair_byte;
            mem[1] <= '0;
            wptr   <= AW'(2);
            rptr   <= '0;
            count  <= CW'(2);
        end else begin
            if (do_push) begin
                mem[wptr] <= push_data;
                wptr      <= bump(wptr);
            end
            if (do_pop)
                rptr <= bump(rptr);
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/scsi_hif_status.sv
// Status, interrupt and sequence-step registers. Applies the register side of
// the immediate commands, the read-to-clear of the interrupt register and the
// terminal-count event. Assumes rd_int and cmd_go never arrive together.
module scsi_hif_status
    import scsi_hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cmd_go,
    input  cmd_kind_e         kind,
    input  logic              rd_int,
    input  logic              tc_hit,
    input  logic              rep_dis,
    output logic [BYTE_W-1:0] int_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [2:0]        seq_q
);

    // Register update: reset, read-clear, command effects, then count event.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            int_q  <= '0;
            stat_q <= '0;
            seq_q  <= '0;
        end else begin
            if (rd_int) begin
                int_q          <= '0;
                stat_q[ST_TC]  <= 1'b0;
                stat_q[ST_PEND] <= 1'b0;
                seq_q          <= SEQ_DONE;
            end
            if (cmd_go) begin
                case (kind)
                    K_FLUSH: begin
                        int_q <= IV_FDONE;
                        seq_q <= '0;
                    end
                    K_BUSRST: begin
                        int_q <= IV_BUSRST;
                        if (!rep_dis)
                            stat_q[ST_PEND] <= 1'b1;
                    end
                    K_ICCS: begin
                        int_q           <= IV_FDONE;
                        stat_q[2:0]     <= PH_MSGIN;
                        stat_q[ST_PEND] <= 1'b1;
                    end
                    K_MSGACC: begin
                        int_q           <= IV_DISC;
                        seq_q           <= '0;
                        stat_q[ST_PEND] <= 1'b1;
                    end
                    K_ENSEL: int_q <= '0;
                    default: ;
                endcase
            end
            if (tc_hit)
                stat_q[ST_TC] <= 1'b1;
        end
    end

endmodule

// File: rtl/scsi_hif_top.sv
// Host register front end of a SCSI bus controller. Decodes register writes
// and reads, runs immediate commands, hands selection commands to an
// external sequencer and drives the level interrupt. Assumes a write and a
// read are not requested together (write wins).
module scsi_hif_top
    import scsi_hif_pkg::*;
#(
    parameter int               FIFO_DEPTH = 16,
    parameter logic [7:0]       CHIP_ID    = 8'h04,
    parameter logic [7:0]       CFG1_RST   = 8'h07,
    localparam int              CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [BYTE_W-1:0] tgt_status,
    input  logic              tc_hit,
    output logic              irq,
    output logic              seq_start,
    output logic [6:0]        seq_op,
    output logic              seq_dma,
    output logic              atn_set,
    output logic              bus_rst_req,
    output logic              cmd_err
);

    cmd_kind_e         kind;
    logic              cmd_dma;
    logic              cmd_go, rd_go, soft_rst;
    logic [BYTE_W-1:0] tcw_lo, tcw_mid, tcr_lo, tcr_mid, cfg1_q;
    logic [BYTE_W-1:0] int_q, stat_q, fifo_head;
    logic [2:0]        seq_q;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_clr;

    assign cmd_go   = host_wr && (host_addr == A_CMD);
    assign rd_go    = host_rd && !host_wr;
    assign soft_rst = cmd_go && (kind == K_CHIPRST);
    assign fifo_clr = soft_rst || (cmd_go && (kind == K_FLUSH || kind == K_MSGACC));
    assign irq      = stat_q[ST_PEND];

    scsi_hif_cmd_dec u_dec (
        .cmd_byte (host_wdata),
        .kind     (kind),
        .dma      (cmd_dma)
    );

    scsi_hif_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .load_pair (cmd_go && (kind == K_ICCS)),
        .pair_byte (tgt_status),
        .push      (host_wr && (host_addr == A_FIFO)),
        .push_data (host_wdata),
        .pop       (rd_go && (host_addr == A_FIFO)),
        .head      (fifo_head),
        .count     (fifo_cnt)
    );

    scsi_hif_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .cmd_go   (cmd_go),
        .kind     (kind),
        .rd_int   (rd_go && (host_addr == A_INTR)),
        .tc_hit   (tc_hit),
        .rep_dis  (cfg1_q[CFG_REPDIS]),
        .int_q    (int_q),
        .stat_q   (stat_q),
        .seq_q    (seq_q)
    );

    // Transfer-count shadows, readable copies and config 1.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tcw_lo  <= '0;
            tcw_mid <= '0;
            tcr_lo  <= '0;
            tcr_mid <= '0;
            cfg1_q  <= CFG1_RST;
        end else if (host_wr) begin
            if (host_addr == A_TCLO)  tcw_lo  <= host_wdata;
            if (host_addr == A_TCMID) tcw_mid <= host_wdata;
            if (host_addr == A_CFG1)  cfg1_q  <= host_wdata;
            if (cmd_go && cmd_dma && kind != K_BAD) begin
                tcr_lo  <= tcw_lo;
                tcr_mid <= tcw_mid;
            end
        end
    end

    // One-cycle strobes toward the sequencer and bus side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_start   <= 1'b0;
            seq_op      <= '0;
            seq_dma     <= 1'b0;
            atn_set     <= 1'b0;
            bus_rst_req <= 1'b0;
            cmd_err     <= 1'b0;
        end else begin
            seq_start   <= cmd_go && (kind == K_SEL);
            atn_set     <= cmd_go && (kind == K_SATN);
            bus_rst_req <= cmd_go && (kind == K_BUSRST);
            cmd_err     <= cmd_go && (kind == K_BAD);
            if (cmd_go && kind == K_SEL) begin
                seq_op  <= host_wdata[6:0];
                seq_dma <= cmd_dma;
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        unique case (host_addr)
            A_TCLO:  host_rdata = tcr_lo;
            A_TCMID: host_rdata = tcr_mid;
            A_FIFO:  host_rdata = fifo_head;
            A_STAT:  host_rdata = stat_q;
            A_INTR:  host_rdata = int_q;
            A_SEQ:   host_rdata = {5'b0, seq_q};
            A_FLAGS: host_rdata = BYTE_W'(fifo_cnt);
            A_CFG1:  host_rdata = cfg1_q;
            A_TCHI:  host_rdata = CHIP_ID;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/scsi_hif_chk.sv
// Checker for the host register front end: temporal rules on the interrupt
// line and the outgoing strobes. Decodes opcodes on its own.
module scsi_hif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic [3:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       irq,
    input logic       seq_start,
    input logic [6:0] seq_op,
    input logic       atn_set,
    input logic       bus_rst_req,
    input logic       cmd_err,
    input logic       rep_dis
);

    logic cmd_wr, op_known, op_sel;
    assign cmd_wr   = host_wr && host_addr == 4'd3;
    assign op_sel   = host_wdata[6:0] inside {7'h41, 7'h42, 7'h43};
    assign op_known = op_sel || (host_wdata[6:0] inside
                      {7'h00, 7'h01, 7'h02, 7'h03, 7'h11, 7'h12, 7'h1a, 7'h44});

    // R2
    int_rd_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == 4'd5) |=> !irq);

    // R3
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_wr));

    // R5
    busrst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && host_wdata[6:0] == 7'h03 && !rep_dis) |=> (irq && bus_rst_req));

    // R10
    sel_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && op_sel) |=> (seq_start && seq_op == $past(host_wdata[6:0])));

    // R11
    bad_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !op_known) |=> (cmd_err && $stable(irq)));

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_start, atn_set, bus_rst_req, cmd_err}));

endmodule

bind scsi_hif_top scsi_hif_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .irq         (irq),
    .seq_start   (seq_start),
    .seq_op      (seq_op),
    .atn_set     (atn_set),
    .bus_rst_req (bus_rst_req),
    .cmd_err     (cmd_err),
    .rep_dis     (cfg1_q[6])
);

// File: tb/scsi_hif_top_tb.sv
// Bench: table-driven register sequence, then directed reset and corner tests.
module scsi_hif_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] TGT_ST = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, tc_hit = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       irq, seq_start, seq_dma, atn_set, bus_rst_req, cmd_err;
    logic [6:0] seq_op;
    int         checks = 0, errors = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_hif_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tgt_status(TGT_ST), .tc_hit(tc_hit), .irq(irq),
        .seq_start(seq_start), .seq_op(seq_op), .seq_dma(seq_dma),
        .atn_set(atn_set), .bus_rst_req(bus_rst_req), .cmd_err(cmd_err)
    );

    // Entry: {read, index, data-or-expected, expected irq, requirement number}
    localparam int NV = 39;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 4'd0, 8'h34, 1'b0, 4'd9},  // R9 shadow write
        {1'b0, 4'd1, 8'h12, 1'b0, 4'd9},
        {1'b1, 4'd0, 8'h00, 1'b0, 4'd9},  // R9 not yet reloaded
        {1'b0, 4'd3, 8'h80, 1'b0, 4'd9},  // R9 DMA nop reloads
        {1'b1, 4'd0, 8'h34, 1'b0, 4'd9},
        {1'b1, 4'd1, 8'h12, 1'b0, 4'd9},
        {1'b0, 4'd2, 8'hA5, 1'b0, 4'd14}, // R14 push
        {1'b0, 4'd2, 8'h5A, 1'b0, 4'd14},
        {1'b1, 4'd7, 8'h02, 1'b0, 4'd14},
        {1'b1, 4'd2, 8'hA5, 1'b0, 4'd14},
        {1'b0, 4'd3, 8'h01, 1'b0, 4'd4},  // R4 flush
        {1'b1, 4'd7, 8'h00, 1'b0, 4'd4},
        {1'b1, 4'd6, 8'h00, 1'b0, 4'd4},
        {1'b1, 4'd5, 8'h08, 1'b0, 4'd2},  // R2 read-clear
        {1'b1, 4'd6, 8'h04, 1'b0, 4'd2},
        {1'b0, 4'd3, 8'h12, 1'b1, 4'd7},  // R7 message accepted
        {1'b1, 4'd4, 8'h80, 1'b1, 4'd3},  // R3 pending bit
        {1'b1, 4'd6, 8'h00, 1'b1, 4'd7},
        {1'b1, 4'd5, 8'h20, 1'b0, 4'd2},
        {1'b1, 4'd4, 8'h00, 1'b0, 4'd2},
        {1'b0, 4'd3, 8'h11, 1'b1, 4'd6},  // R6 initiator complete
        {1'b1, 4'd4, 8'h87, 1'b1, 4'd6},
        {1'b1, 4'd7, 8'h02, 1'b1, 4'd6},
        {1'b1, 4'd2, 8'h3C, 1'b1, 4'd6},
        {1'b1, 4'd2, 8'h00, 1'b1, 4'd6},
        {1'b1, 4'd2, 8'h00, 1'b1, 4'd14}, // R14 empty read
        {1'b1, 4'd7, 8'h00, 1'b1, 4'd14},
        {1'b1, 4'd5, 8'h08, 1'b0, 4'd6},
        {1'b1, 4'd4, 8'h07, 1'b0, 4'd2},
        {1'b0, 4'd3, 8'h03, 1'b1, 4'd5},  // R5 bus reset reported
        {1'b1, 4'd5, 8'h80, 1'b0, 4'd5},
        {1'b0, 4'd8, 8'h47, 1'b0, 4'd5},  // R5 mask reporting
        {1'b1, 4'd8, 8'h47, 1'b0, 4'd5},
        {1'b0, 4'd3, 8'h03, 1'b0, 4'd5},
        {1'b1, 4'd4, 8'h07, 1'b0, 4'd5},
        {1'b1, 4'd5, 8'h80, 1'b0, 4'd5},
        {1'b0, 4'd3, 8'h12, 1'b1, 4'd8},  // R8 enable selection
        {1'b0, 4'd3, 8'h44, 1'b1, 4'd8},
        {1'b1, 4'd5, 8'h00, 1'b0, 4'd8}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset defaults
        rd(4'd9, rv); chk("R1 id", rv, 8'h04);
        rd(4'd8, rv); chk("R1 cfg1", rv, 8'h07);
        rd(4'd4, rv); chk("R1 status", rv, 8'h00);
        rd(4'd0, rv); chk("R1 tclo", rv, 8'h00);
        rd(4'd7, rv); chk("R1 flags", rv, 8'h00);
        rd(4'd5, rv); chk("R1 intr", rv, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            if (v[17]) begin
                rd(v[16:13], rv);
                chk(tag, rv, v[12:5]);
            end else begin
                wr(v[16:13], v[12:5]);
            end
            chk({tag, " irq"}, {7'b0, irq}, {7'b0, v[4]});
        end

        // R2 terminal-count bit cleared by interrupt read
        @(negedge clk); tc_hit = 1'b1;
        @(negedge clk); tc_hit = 1'b0;
        rd(4'd4, rv); chk("R2 tc set", rv, 8'h17);
        rd(4'd5, rv);
        rd(4'd4, rv); chk("R2 tc clear", rv, 8'h07);

        // R10 selection handoff
        wr(4'd3, 8'hC2);
        chk("R10 start", {7'b0, seq_start}, 8'h01);
        chk("R10 op", {1'b0, seq_op}, 8'h42);
        chk("R10 dma", {7'b0, seq_dma}, 8'h01);
        @(negedge clk);
        chk("R10 one cycle", {7'b0, seq_start}, 8'h00);
        rd(4'd5, rv); chk("R10 intr kept", rv, 8'h00);

        // R11 unrecognised opcode
        wr(4'd0, 8'h99);
        wr(4'd3, 8'hFF);
        chk("R11 err", {7'b0, cmd_err}, 8'h01);
        rd(4'd0, rv); chk("R11 no reload", rv, 8'h34);
        wr(4'd3, 8'h10);
        chk("R11 err2", {7'b0, cmd_err}, 8'h01);
        rd(4'd5, rv); chk("R11 intr kept", rv, 8'h00);

        // R13 set-ATN and nop
        wr(4'd3, 8'h1A);
        chk("R13 atn", {7'b0, atn_set}, 8'h01);
        wr(4'd3, 8'h00);
        chk("R13 nop strobes", {4'b0, seq_start, atn_set, bus_rst_req, cmd_err}, 8'h00);

        // R5 bus reset request while reporting masked
        wr(4'd3, 8'h03);
        chk("R5 req", {7'b0, bus_rst_req}, 8'h01);
        chk("R5 masked irq", {7'b0, irq}, 8'h00);

        // R12 chip reset
        wr(4'd2, 8'h77);
        wr(4'd3, 8'h12);
        wr(4'd2, 8'h66);
        wr(4'd3, 8'h02);
        rd(4'd8, rv); chk("R12 cfg1", rv, 8'h07);
        rd(4'd9, rv); chk("R12 id", rv, 8'h04);
        rd(4'd0, rv); chk("R12 tclo", rv, 8'h00);
        rd(4'd1, rv); chk("R12 tcmid", rv, 8'h00);
        rd(4'd4, rv); chk("R12 status", rv, 8'h00);
        rd(4'd7, rv); chk("R12 flags", rv, 8'h00);
        rd(4'd5, rv); chk("R12 intr", rv, 8'h00);
        chk("R12 irq", {7'b0, irq}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule